// File: doc/BRIEF.md
# Signed Multiply-Accumulate Datapath

This block multiplies a 25-bit two's-complement operand by an 18-bit two's-complement operand. It sign-extends the 43-bit product to 48 bits and adds it into a running 48-bit sum. A caller raises `inValid` with each operand pair. The caller may raise `inClear` on the same cycle, and the sum then restarts from that pair's product. The block presents the updated sum on `result` and flags it with `outValid`.

Three optional register stages sit on the path, and each is chosen at elaboration time on its own. The first is a register on each operand before the multiplier. The second is a register on the product before the adder. The third is a register on the sum at the output. A stage that is not chosen becomes a wire. The valid and clear tags travel through exactly the same stages as the data they belong to, so latency always equals the number of chosen stages. The running-sum register itself is always present, because it holds the state.

Top module: `sgn_mac`

## Requirements
- R1: The product is the signed product of `opA` (25-bit two's complement) and `opB` (18-bit two's complement), sign-extended to 48 bits before it is added.
- R2: Each valid pair adds its extended product to the running sum modulo 2^48, with no saturation and no overflow indication.
- R3: A pair given with `inClear`=1 and `inValid`=1 makes the reported sum equal to that pair's product alone, and later pairs add onto that value.
- R4: `outValid` is high exactly N cycles after the `inValid` cycle of the pair, where N is the number of enabled register stages (0 to 3). In that cycle `result` carries the sum through that pair. Results leave in the order the pairs came in.
- R5: While `inValid`=0, the values on `opA`, `opB` and `inClear` have no effect on the running sum.
- R6: A synchronous `rst` zeroes the running sum and `result`, and drops `outValid`. The first pair after reset reports its own product.
- R7: Parameters `IN_STAGE`, `MUL_STAGE` and `OUT_STAGE` each enable their register on their own, and every combination gives the same sums with latency N.
- R8: A new pair is accepted every cycle, and back-to-back pairs produce back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Marks `opA`/`opB` as a pair to accumulate |
| inClear | input | 1 | With `inValid`, restart the sum from this product |
| opA | input | 25 | Signed multiplicand |
| opB | input | 18 | Signed multiplier |
| result | output | 48 | Running sum, wraps modulo 2^48 |
| outValid | output | 1 | `result` holds the sum through a new pair |

## Verification
Small hand-picked pairs of mixed sign show whether the product is signed and sign-extended correctly. The extreme operand corners tell a correct 43-bit product apart from a truncated or unsigned one. Long back-to-back runs of the largest positive product push the sum past 2^48, which separates wrap-around from saturation. They also show one result per cycle. Random streams with gaps and stray clear strobes on idle cycles run on three stage configurations at once (three, zero and one stage). These show whether latency follows the configuration and whether idle inputs leak into the sum.

// File: rtl/sgn_mac_pkg.sv
package sgn_mac_pkg;

  // Strobes handed from the control tracker to the datapath.
  typedef struct packed {
    logic inLoad;    // capture operands into the input stage
    logic mulLoad;   // capture product into the post-multiply stage
    logic accLoad;   // a valid product is at the adder this cycle
    logic accClear;  // restart the sum from the product at the adder
  } macStrobes_t;

  function automatic int stageCount(input bit s0, input bit s1, input bit s2);
    return int'(s0) + int'(s1) + int'(s2);
  endfunction

endpackage

// File: rtl/sgn_mac_ctrl.sv
module sgn_mac_ctrl
  import sgn_mac_pkg::*;
#(
  parameter bit IN_STAGE  = 1'b1,
  parameter bit MUL_STAGE = 1'b1,
  parameter bit OUT_STAGE = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        inClear,
  output macStrobes_t strobes,
  output logic        outValid
);

  localparam int LAT = stageCount(IN_STAGE, MUL_STAGE, OUT_STAGE);

  logic validS1, clearS1, validS2, clearS2;

  // Tags after the input stage
  generate
    if (IN_STAGE) begin : g_inTag
      logic validQ, clearQ;
      always_ff @(posedge clk) begin
        if (rst) begin
          validQ <= 1'b0;
          clearQ <= 1'b0;
        end else begin
          validQ <= inValid;
          clearQ <= inClear & inValid;
        end
      end
      assign validS1 = validQ;
      assign clearS1 = clearQ;
    end else begin : g_inTagWire
      assign validS1 = inValid;
      assign clearS1 = inClear & inValid;
    end
  endgenerate

  // Tags after the post-multiply stage
  generate
    if (MUL_STAGE) begin : g_mulTag
      logic validQ, clearQ;
      always_ff @(posedge clk) begin
        if (rst) begin
          validQ <= 1'b0;
          clearQ <= 1'b0;
        end else begin
          validQ <= validS1;
          clearQ <= clearS1;
        end
      end
      assign validS2 = validQ;
      assign clearS2 = clearQ;
    end else begin : g_mulTagWire
      assign validS2 = validS1;
      assign clearS2 = clearS1;
    end
  endgenerate

  // Output-stage tag
  generate
    if (OUT_STAGE) begin : g_outTag
      logic validQ;
      always_ff @(posedge clk) begin
        if (rst) validQ <= 1'b0;
        else     validQ <= validS2;
      end
      assign outValid = validQ;
    end else begin : g_outTagWire
      assign outValid = validS2;
    end
  endgenerate

  always_comb begin
    strobes.inLoad   = inValid;
    strobes.mulLoad  = validS1;
    strobes.accLoad  = validS2;
    strobes.accClear = clearS2 & validS2;
  end

  // Cycles since reset, saturating at 3, so the latency check never looks back past reset.
  logic [1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (rst)                sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  generate
    if (LAT > 0) begin : g_latChk
      // R4: output valid follows input valid by exactly LAT cycles
      a_r4_latency: assert property (@(posedge clk) disable iff (rst)
        (int'(sinceRst) >= LAT) |-> (outValid == $past(inValid, LAT)));
    end
  endgenerate

endmodule

// File: rtl/sgn_mac_datapath.sv
module sgn_mac_datapath
  import sgn_mac_pkg::*;
#(
  parameter int A_W       = 25,
  parameter int B_W       = 18,
  parameter int ACC_W     = 48,
  parameter bit IN_STAGE  = 1'b1,
  parameter bit MUL_STAGE = 1'b1,
  parameter bit OUT_STAGE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  macStrobes_t      strobes,
  input  logic [A_W-1:0]   opA,
  input  logic [B_W-1:0]   opB,
  output logic [ACC_W-1:0] result
);

  localparam int PROD_W = A_W + B_W;
  localparam int EXT_W  = ACC_W - PROD_W;

  logic [A_W-1:0]         aStage;
  logic [B_W-1:0]         bStage;
  logic signed [PROD_W-1:0] prodRaw;
  logic [PROD_W-1:0]      prodStage;
  logic [ACC_W-1:0]       prodExt;
  logic [ACC_W-1:0]       accQ;
  logic [ACC_W-1:0]       accNext;
  logic [ACC_W-1:0]       sumView;

  // Input stage
  generate
    if (IN_STAGE) begin : g_inReg
      logic [A_W-1:0] aQ;
      logic [B_W-1:0] bQ;
      always_ff @(posedge clk) begin
        if (rst) begin
          aQ <= '0;
          bQ <= '0;
        end else if (strobes.inLoad) begin
          aQ <= opA;
          bQ <= opB;
        end
      end
      assign aStage = aQ;
      assign bStage = bQ;
    end else begin : g_inWire
      assign aStage = opA;
      assign bStage = opB;
    end
  endgenerate

  assign prodRaw = $signed(aStage) * $signed(bStage);

  // Post-multiply stage
  generate
    if (MUL_STAGE) begin : g_mulReg
      logic [PROD_W-1:0] pQ;
      always_ff @(posedge clk) begin
        if (rst)                  pQ <= '0;
        else if (strobes.mulLoad) pQ <= prodRaw;
      end
      assign prodStage = pQ;
    end else begin : g_mulWire
      assign prodStage = prodRaw;
    end
  endgenerate

  assign prodExt = {{EXT_W{prodStage[PROD_W-1]}}, prodStage};

  always_comb begin
    if (strobes.accClear) accNext = prodExt;
    else                  accNext = accQ + prodExt;
    sumView = strobes.accLoad ? accNext : accQ;
  end

  always_ff @(posedge clk) begin
    if (rst)                  accQ <= '0;
    else if (strobes.accLoad) accQ <= accNext;
  end

  // Output stage
  generate
    if (OUT_STAGE) begin : g_outReg
      logic [ACC_W-1:0] rQ;
      always_ff @(posedge clk) begin
        if (rst)                  rQ <= '0;
        else if (strobes.accLoad) rQ <= accNext;
      end
      assign result = rQ;
    end else begin : g_outWire
      assign result = sumView;
    end
  endgenerate

  // R5: the sum only moves when a valid product reaches the adder
  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !strobes.accLoad |=> $stable(accQ));

  // R2: a plain accumulate adds the extended product, modulo 2^ACC_W
  a_r2_wrap_add: assert property (@(posedge clk) disable iff (rst)
    (strobes.accLoad && !strobes.accClear) |=> (accQ == $past(accQ) + $past(prodExt)));

  // R3: a clear loads the product alone
  a_r3_clear_loads: assert property (@(posedge clk) disable iff (rst)
    (strobes.accLoad && strobes.accClear) |=> (accQ == $past(prodExt)));

  // R6: the sum is zero right after reset
  a_r6_reset_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (accQ == '0));

endmodule

// File: rtl/sgn_mac.sv
module sgn_mac
  import sgn_mac_pkg::*;
#(
  parameter int A_W       = 25,
  parameter int B_W       = 18,
  parameter int ACC_W     = 48,
  parameter bit IN_STAGE  = 1'b1,
  parameter bit MUL_STAGE = 1'b1,
  parameter bit OUT_STAGE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             inClear,
  input  logic [A_W-1:0]   opA,
  input  logic [B_W-1:0]   opB,
  output logic [ACC_W-1:0] result,
  output logic             outValid
);

  macStrobes_t strobes;

  sgn_mac_ctrl #(
    .IN_STAGE (IN_STAGE),
    .MUL_STAGE(MUL_STAGE),
    .OUT_STAGE(OUT_STAGE)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inClear (inClear),
    .strobes (strobes),
    .outValid(outValid)
  );

  sgn_mac_datapath #(
    .A_W      (A_W),
    .B_W      (B_W),
    .ACC_W    (ACC_W),
    .IN_STAGE (IN_STAGE),
    .MUL_STAGE(MUL_STAGE),
    .OUT_STAGE(OUT_STAGE)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );

  // R6: no output valid on the cycle after reset
  a_r6_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) && (OUT_STAGE || !inValid) |-> !outValid);

endmodule

// File: tb/sgn_mac_bench.sv
module sgn_mac_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        inClear = 1'b0;
  logic [24:0] opA = '0;
  logic [17:0] opB = '0;

  logic [47:0] res [3];
  logic        ov  [3];
  int          lat [3] = '{3, 0, 1};

  always #10 clk = ~clk;   // 50 MHz

  sgn_mac u_sgn_mac (
    .clk(clk), .rst(rst), .inValid(inValid), .inClear(inClear),
    .opA(opA), .opB(opB), .result(res[0]), .outValid(ov[0]));

  sgn_mac #(.IN_STAGE(1'b0), .MUL_STAGE(1'b0), .OUT_STAGE(1'b0)) u_sgn_mac_flat (
    .clk(clk), .rst(rst), .inValid(inValid), .inClear(inClear),
    .opA(opA), .opB(opB), .result(res[1]), .outValid(ov[1]));

  sgn_mac #(.IN_STAGE(1'b0), .MUL_STAGE(1'b1), .OUT_STAGE(1'b0)) u_sgn_mac_mid (
    .clk(clk), .rst(rst), .inValid(inValid), .inClear(inClear),
    .opA(opA), .opB(opB), .result(res[2]), .outValid(ov[2]));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit monOn = 1'b0;

  logic [47:0] expQ [3][$];
  int          dueQ [3][$];
  string       tagQ [3][$];
  logic [47:0] model = '0;

  task automatic report(input string tag, input string what,
                        input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: one valid pair per call, pushes the expected sum for every instance
  task automatic drive(input logic [24:0] a, input logic [17:0] b,
                       input logic clr, input string tag);
    longint sa, sb, p;
    @(negedge clk);
    opA = a; opB = b; inClear = clr; inValid = 1'b1;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    p  = sa * sb;
    model = clr ? p[47:0] : model + p[47:0];
    for (int i = 0; i < 3; i++) begin
      expQ[i].push_back(model);
      dueQ[i].push_back(cyc + lat[i]);
      tagQ[i].push_back(tag);
    end
  endtask

  // Idle cycle with junk on the data and clear inputs (R5)
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
      opA = 25'($urandom);
      opB = 18'($urandom);
      inClear = 1'($urandom);
    end
  endtask

  // Monitor: compares each output against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (monOn) begin
        for (int i = 0; i < 3; i++) begin
          if (dueQ[i].size() > 0 && dueQ[i][0] == cyc) begin
            report({tagQ[i][0], "/R4"}, $sformatf("inst%0d outValid", i), 48'(ov[i]), 48'd1);
            report(tagQ[i][0], $sformatf("inst%0d result", i), res[i], expQ[i][0]);
            void'(expQ[i].pop_front());
            void'(dueQ[i].pop_front());
            void'(tagQ[i].pop_front());
          end else if (ov[i] !== 1'b0) begin
            report("R4", $sformatf("inst%0d unexpected outValid", i), 48'(ov[i]), 48'd0);
          end
        end
      end
    end
  end

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model = '0;
    #5;
    for (int i = 0; i < 3; i++) begin
      report("R6", $sformatf("inst%0d outValid after reset", i), 48'(ov[i]), 48'd0);
      report("R6", $sformatf("inst%0d result after reset", i), res[i], 48'd0);
    end
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish();
  end

  initial begin
    doReset();
    monOn = 1'b1;

    // R3, R1: fresh start and mixed signs
    drive(25'd3, 18'd4, 1'b1, "R3");
    drive(-25'sd5, 18'd7, 1'b0, "R1");
    drive(25'd9, -18'sd11, 1'b0, "R1");
    drive(-25'sd13, -18'sd2, 1'b0, "R1");
    idle(5);
    // R1: operand corners
    drive(25'h1000000, 18'h20000, 1'b1, "R1");   // most negative * most negative
    drive(25'h0FFFFFF, 18'h20000, 1'b0, "R1");   // most positive * most negative
    drive(25'h0FFFFFF, 18'h1FFFF, 1'b0, "R1");   // most positive * most positive
    drive(25'h1FFFFFF, 18'd1, 1'b0, "R1");       // -1 * 1
    idle(4);
    // R5: junk and clear while idle must not disturb the sum
    drive(25'd1, 18'd1, 1'b0, "R5");
    idle(6);
    drive(25'd2, 18'd3, 1'b0, "R5");
    idle(5);
    // R2, R8: 130 back-to-back largest products wrap past 2^48
    drive(25'h1000000, 18'h20000, 1'b1, "R2");
    for (int k = 0; k < 129; k++) drive(25'h1000000, 18'h20000, 1'b0, "R8");
    drive(25'd1, 18'd1, 1'b0, "R2");
    idle(5);
    // R7, R4: random stream with gaps, three configurations in parallel
    for (int k = 0; k < 200; k++) begin
      drive(25'($urandom), 18'($urandom), 1'(($urandom % 8) == 0), "R7");
      if ($urandom % 3 == 0) idle(int'($urandom % 4));
    end
    idle(6);
    // R6: reset after activity, then the first pair stands alone
    drive(25'd100, 18'd100, 1'b0, "R6");
    idle(6);
    doReset();
    drive(25'd6, 18'd7, 1'b0, "R6");
    idle(6);
    for (int i = 0; i < 3; i++)
      report("R4", $sformatf("inst%0d pending items", i), 48'(expQ[i].size()), 48'd0);
    finish();
  end

endmodule